// File: doc/BRIEF.md
# Programmable Watchdog with Reset Steering

This block is a watchdog timer driven by a 16 Hz enable strobe and programmed through a single control byte. Software writes the byte to set the timeout and to choose what happens on expiry. The timeout is a 5-bit multiplier scaled by a power of four. When the count runs out, a timeout flag is set. The block then either raises a one-cycle interrupt or requests a system reset, depending on a steering bit held in the same byte.

Software keeps the watchdog alive in one of two ways. It can rewrite the control byte, or it can read the flags register, which reloads the count from the byte already stored. A steered reset wipes the control byte. It also pulses a clear for a century bit held elsewhere in the chip, and holds the reset request for a fixed number of clock cycles. The watchdog then stays off until software programs it again. A multiplier of zero keeps the watchdog idle.

Top module: `wdog_steer`

## Requirements
- R1: The control byte carries the resolution code R in bits [1:0], the multiplier M in bits [6:2] and the steering bit in bit 7. After a load, the flag `expired` rises on the (M × 4^R)-th clock edge that has `tick` high.
- R2: Only clock edges with `tick` high advance the count. Edges with `tick` low leave the remaining time unchanged.
- R3: A write (`cfg_we`) stores `cfg_wdata`, which `cfg_q` shows from the next cycle. The write also clears `expired` and restarts the count from the new value.
- R4: A flags read (`flags_rd`) clears `expired` and restarts the count from the value already in `cfg_q`.
- R5: Once set, `expired` stays high until the next write or flags read.
- R6: On expiry with bit 7 clear, `irq` is high for exactly one cycle, in the cycle in which `expired` rises, and `cfg_q` is left unchanged.
- R7: On expiry with bit 7 set, `cfg_q` becomes 0x00 and `century_clr` pulses for one cycle. In the same cycle `reset_req` rises and then stays high for exactly RST_HOLD cycles. `irq` stays low.
- R8: With M = 0 the watchdog never expires. After a steered reset it stays disabled, and flags reads do not re-arm it, until the next write.
- R9: Each load expires at most once. After an expiry, no further `irq` or flag event occurs until a write or flags read reloads the count.
- R10: When events coincide, a write takes priority over a flags read, and a flags read takes priority over a tick. A reload in the same cycle as the final tick suppresses that expiry.
- R11: After reset, `cfg_q` is 0x00 and `expired`, `irq`, `reset_req` and `century_clr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 16 Hz time-base enable, one cycle per period |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| flags_rd | input | 1 | Flags register read strobe (kicks the watchdog) |
| cfg_q | output | 8 | Current control byte |
| expired | output | 1 | Timeout flag |
| irq | output | 1 | One-cycle interrupt pulse on non-steered expiry |
| reset_req | output | 1 | Reset request, held RST_HOLD cycles |
| century_clr | output | 1 | One-cycle clear of the external century bit |

## Verification
The bench builds the block with RST_HOLD = 4, so each reset-request window can be counted in full a few cycles after every steered expiry. It holds `tick` high on every cycle of the sweep. This makes timeouts of up to 1984 ticks cheap enough to cover every multiplier, resolution code and steering value, 256 control bytes in all, with the exact expiry edge compared against M × 4^R. A sparse tick pattern and coincident write, read and tick events cover the gating and the priority order.

// File: rtl/wdog_steer.sv
module wdog_steer #(
  parameter int RST_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic       flags_rd,
  output logic [7:0] cfg_q,
  output logic       expired,
  output logic       irq,
  output logic       reset_req,
  output logic       century_clr
);
  localparam int MULT_W = 5;
  localparam int RES_W  = 2;
  localparam int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1);
  localparam int HOLD_W = $clog2(RST_HOLD + 1);

  logic [CNT_W-1:0]  remain;
  logic [HOLD_W-1:0] hold_cnt;

  function automatic logic [CNT_W-1:0] span(input logic [7:0] v);
    logic [CNT_W-1:0] m;
    m = CNT_W'(v[RES_W +: MULT_W]);
    return m << (2 * v[RES_W-1:0]);
  endfunction

  wire last_tick = tick && (remain == CNT_W'(1));

  assign reset_req = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      remain      <= '0;
      hold_cnt    <= '0;
      expired     <= 1'b0;
      irq         <= 1'b0;
      century_clr <= 1'b0;
    end else begin
      irq         <= 1'b0;
      century_clr <= 1'b0;
      if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      if (cfg_we) begin
        cfg_q   <= cfg_wdata;
        remain  <= span(cfg_wdata);
        expired <= 1'b0;
      end else if (flags_rd) begin
        remain  <= span(cfg_q);
        expired <= 1'b0;
      end else if (tick && remain != '0) begin
        remain <= remain - 1'b1;
        if (last_tick) begin
          expired <= 1'b1;
          if (cfg_q[7]) begin
            cfg_q       <= '0;
            hold_cnt    <= HOLD_W'(RST_HOLD);
            century_clr <= 1'b1;
          end else begin
            irq <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module wdog_steer_chk #(
  parameter int RST_HOLD = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       flags_rd,
  input logic [7:0] cfg_q,
  input logic       expired,
  input logic       irq,
  input logic       reset_req,
  input logic       century_clr
);
  int unsigned hcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hcnt <= 0;
    else if (reset_req) hcnt <= hcnt + 1;
    else hcnt <= 0;
  end

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    century_clr |=> !century_clr);
  assert_steer_wipe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    century_clr |-> (cfg_q == 8'h00 && reset_req && !irq));
  assert_rst_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> century_clr);
  assert_hold_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_req) |-> ($past(hcnt) >= RST_HOLD - 1));
  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> (irq ^ century_clr));
  assert_kick_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we || flags_rd) |=> !expired);
  assert_event_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || century_clr) |-> $rose(expired));
endmodule

bind wdog_steer wdog_steer_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .flags_rd(flags_rd),
  .cfg_q(cfg_q), .expired(expired), .irq(irq), .reset_req(reset_req),
  .century_clr(century_clr)
);

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       flags_rd = 1'b0;
  logic [7:0] cfg_q;
  logic       expired, irq, reset_req, century_clr;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  wdog_steer #(.RST_HOLD(HOLD)) u_wdog_steer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .flags_rd(flags_rd), .cfg_q(cfg_q),
    .expired(expired), .irq(irq), .reset_req(reset_req),
    .century_clr(century_clr)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
      finish_run();
    end
  end

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wait_expire(input int limit, output int k);
    k = 0;
    while (!expired && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic run_cfg(input int m, input int r, input bit st);
    logic [7:0] v;
    int t, k, hc;
    bit seen;
    v = {st, m[4:0], r[1:0]};
    t = m * (1 << (2 * r));
    write_cfg(v);
    chk(expired == 1'b0, "R3 flag clear", int'(expired), 0);
    chk(cfg_q == v, "R3 readback", int'(cfg_q), int'(v));
    if (t == 0) begin
      seen = 1'b0;
      repeat (64) begin
        @(negedge clk);
        if (expired || irq || reset_req) seen = 1'b1;
      end
      chk(!seen, "R8 zero multiplier idle", int'(seen), 0);
      return;
    end
    wait_expire(t + 3, k);
    chk(k == t, "R1 timeout edge", k, t);
    chk(irq == !st, "R6 irq at expiry", int'(irq), int'(!st));
    chk(century_clr == st, "R7 century clear", int'(century_clr), int'(st));
    chk(reset_req == st, "R7 reset start", int'(reset_req), int'(st));
    chk(cfg_q == (st ? 8'h00 : v), "R6 R7 byte after expiry", int'(cfg_q), st ? 0 : int'(v));
    if (st) begin
      hc = 0;
      while (reset_req && hc < 20) begin
        hc++;
        @(negedge clk);
      end
      chk(hc == HOLD, "R7 hold length", hc, HOLD);
      @(negedge clk); flags_rd = 1'b1;
      @(negedge clk); flags_rd = 1'b0;
      seen = 1'b0;
      repeat (8) begin
        @(negedge clk);
        if (expired || irq || reset_req) seen = 1'b1;
      end
      chk(!seen, "R8 disabled after steer", int'(seen), 0);
    end else begin
      @(negedge clk);
      chk(irq == 1'b0, "R6 irq one cycle", int'(irq), 0);
    end
  endtask

  initial begin
    int k;
    bit seen;
    repeat (3) @(negedge clk);
    chk(cfg_q == 8'h00, "R11 reset byte", int'(cfg_q), 0);
    chk({expired, irq, reset_req, century_clr} == 4'b0, "R11 reset outputs",
        int'({expired, irq, reset_req, century_clr}), 0);
    rst_n = 1'b1;

    tick = 1'b1;
    for (int st = 0; st < 2; st++)
      for (int r = 0; r < 4; r++)
        for (int m = 0; m < 32; m++)
          run_cfg(m, r, st[0]);

    // R9 and R5: one-shot, flag holds, then R4 read clears it
    write_cfg({1'b0, 5'd3, 2'd0});
    wait_expire(10, k);
    seen = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
    chk(!seen, "R9 no second expiry", int'(seen), 0);
    chk(expired == 1'b1, "R5 flag holds", int'(expired), 1);
    @(negedge clk); flags_rd = 1'b1;
    @(negedge clk); flags_rd = 1'b0;
    chk(expired == 1'b0, "R4 read clears flag", int'(expired), 0);
    wait_expire(10, k);
    chk(k == 3, "R4 read reloads", k, 3);

    // R4: kick mid-count restarts the full timeout
    write_cfg({1'b0, 5'd3, 2'd0});
    @(negedge clk); flags_rd = 1'b1;
    @(negedge clk); flags_rd = 1'b0;
    chk(expired == 1'b0, "R4 kick no expiry", int'(expired), 0);
    wait_expire(10, k);
    chk(k == 3, "R4 kick restart", k, 3);

    // R10: write and read together, write wins
    write_cfg({1'b0, 5'd2, 2'd0});
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = {1'b0, 5'd5, 2'd0}; flags_rd = 1'b1;
    @(negedge clk); cfg_we = 1'b0; flags_rd = 1'b0;
    chk(expired == 1'b0, "R10 reload beats last tick", int'(expired), 0);
    chk(cfg_q == {1'b0, 5'd5, 2'd0}, "R10 write wins", int'(cfg_q), int'({1'b0, 5'd5, 2'd0}));
    wait_expire(10, k);
    chk(k == 5, "R10 new timeout", k, 5);

    // R2: sparse ticks, every third edge
    tick = 1'b0;
    write_cfg({1'b0, 5'd2, 2'd0});
    k = 0;
    for (int i = 1; i <= 9; i++) begin
      tick = (i % 3 == 0);
      @(negedge clk);
      if (expired && k == 0) k = i;
    end
    tick = 1'b0;
    chk(k == 6, "R2 gated ticks", k, 6);

    finish_run();
  end
endmodule